// File: doc/BRIEF.md
# Host Controller Interrupt Status, Mask and Routing Unit

This unit collects the interrupt sources of a low-pin-count host controller into one summary interrupt line and also steers each of the seventeen serial interrupt requests onto one of four routed interrupt lines. Each source is latched into a sticky status bit. Software clears a status bit by writing 1 to it. A mask register with the same bit layout gates both the summary line and the routed lines.

Bus error events arrive as single-cycle pulses together with the address of the failing cycle. The first such error after the error status bits have all been cleared captures that address into a read-only register. Later errors do not overwrite it until software clears the error bits again. Two 32-bit route registers hold 2-bit destination fields, one field per serial request, and the routed lines are decoded from those fields.

Software reaches all registers through a plain 32-bit write strobe with a byte address. Read data is a combinational function of the address.

Top module: `irq_hub`

## Requirements
- R1: After reset, every register reads 0, `irq_o` and `route_irq_o` are low, and every serial request is therefore routed to output 0.
- R2: A source pulse sets its status bit (at offset 0x38) in the next cycle, and the bit stays set until software clears it. Serial request i maps to bit 31−i, the bus-reset event to bit 10, error pulse k (k = 0..5) to bit 2+k, and bus-master request k (k = 0..1) to bit k.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. When a source pulse and a clearing write for the same bit land in the same cycle, the bit stays set.
- R4: The mask register at offset 0x34 is writable and readable on the implemented bits (31..15, 10, 7..0, i.e. 0xFFFF84FF). The other bits read 0, and the same holds for status.
- R5: `irq_o` is high exactly when some status bit and its mask bit are both set.
- R6: The route field of serial request i is 2 bits wide. For i < 14 it sits in the register at offset 0x0C at shift 26−2i. For i ≥ 14 it sits in the register at offset 0x08 at shift 22−2(i−14).
- R7: `route_irq_o[k]` is high exactly when some serial request status bit is set, its mask bit is set, and its route field equals k.
- R8: The error-address register (offset 0x40) loads `err_addr_i` when an error pulse arrives while status bits 7..2 are all 0. It holds while any of those bits is set.
- R9: Both route registers are full 32-bit read/write registers. Bits that hold no route field read back as written.
- R10: Writes to the error-address register are ignored. A status write never sets a bit. Any address other than 0x08, 0x0C, 0x34, 0x38 and 0x40 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| err_evt_i | input | 6 | Bus error pulses, one per error class |
| err_addr_i | input | 32 | Address that accompanies an error pulse |
| bus_rst_evt_i | input | 1 | Bus-reset detect pulse |
| bm_req_i | input | 2 | Bus-master request pulses |
| sirq_req_i | input | 17 | Serial interrupt requests |
| irq_o | output | 1 | Summary interrupt |
| route_irq_o | output | 4 | Routed serial interrupt outputs |

## Verification
The hardest case to reach is a source pulse and a write-1-to-clear of the same status bit landing on the same clock edge. The stimulus drives the bus-reset pulse and a clearing write in one cycle and then reads the bit back. Error-address holding needs a second error to arrive while the first is still latched, and a fresh capture after clearing. The stimulus chains these three steps with different addresses. Every route field position is covered by programming request i to output i mod 4, then firing each request on its own with all other status bits cleared.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int DW         = 32;
    localparam int AW         = 8;
    localparam int NUM_SIRQ   = 17;
    localparam int NUM_ERR    = 6;
    localparam int NUM_BM     = 2;
    localparam int NUM_ROUTE  = 4;
    localparam int RF_W       = $clog2(NUM_ROUTE);
    localparam int SIRQ_SPLIT = 14;
    localparam int RST_BIT    = 10;
    localparam int ERR_LSB    = 2;
    localparam int BM_LSB     = 0;

    localparam logic [AW-1:0] OFS_ROUTE_HI = 8'h08;
    localparam logic [AW-1:0] OFS_ROUTE_LO = 8'h0C;
    localparam logic [AW-1:0] OFS_MASK     = 8'h34;
    localparam logic [AW-1:0] OFS_STAT     = 8'h38;
    localparam logic [AW-1:0] OFS_EADDR    = 8'h40;

    localparam logic [DW-1:0] ONE = DW'(1);

    // Bits that exist in both status and mask.
    localparam logic [DW-1:0] IMPL_MASK =
        ({DW{1'b1}} << (DW - NUM_SIRQ)) |
        (ONE << RST_BIT) |
        (((ONE << NUM_ERR) - ONE) << ERR_LSB) |
        (((ONE << NUM_BM) - ONE) << BM_LSB);

    // Bit offset of the route field that belongs to serial request idx.
    function automatic int route_shift(input int idx);
        if (idx < SIRQ_SPLIT)
            return DW - 2 - (4 + RF_W * idx);
        else
            return DW - 2 - (8 + RF_W * (idx - SIRQ_SPLIT));
    endfunction
endpackage

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_hub_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_stat_i,
    input  logic                wr_mask_i,
    input  logic [DW-1:0]       wdata_i,
    input  logic [NUM_ERR-1:0]  err_evt_i,
    input  logic [DW-1:0]       err_addr_i,
    input  logic                bus_rst_evt_i,
    input  logic [NUM_BM-1:0]   bm_req_i,
    input  logic [NUM_SIRQ-1:0] sirq_req_i,
    output logic [DW-1:0]       status_o,
    output logic [DW-1:0]       mask_o,
    output logic [DW-1:0]       eaddr_o
);
    typedef struct packed {
        logic [DW-1:0] status;
        logic [DW-1:0] mask;
        logic [DW-1:0] eaddr;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic [DW-1:0] evt_vec;
    logic [DW-1:0] clr_vec;
    logic          err_idle;

    always_comb begin
        evt_vec = '0;
        for (int i = 0; i < NUM_SIRQ; i++) evt_vec[DW-1-i] = sirq_req_i[i];
        evt_vec[RST_BIT] = bus_rst_evt_i;
        for (int k = 0; k < NUM_ERR; k++) evt_vec[ERR_LSB+k] = err_evt_i[k];
        for (int k = 0; k < NUM_BM; k++)  evt_vec[BM_LSB+k]  = bm_req_i[k];

        clr_vec  = wr_stat_i ? wdata_i : '0;
        err_idle = (st_q.status[ERR_LSB +: NUM_ERR] == '0);

        st_d = st_q;
        // Clear first, then set: a same-cycle event keeps its bit.
        st_d.status = ((st_q.status & ~clr_vec) | evt_vec) & IMPL_MASK;
        if (wr_mask_i) st_d.mask = wdata_i & IMPL_MASK;
        if ((|err_evt_i) && err_idle) st_d.eaddr = err_addr_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign eaddr_o  = st_q.eaddr;
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_hub_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] route_lo_o,
    output logic [DW-1:0] route_hi_o
);
    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
    } route_state_t;

    route_state_t rt_d, rt_q;

    always_comb begin
        rt_d = rt_q;
        if (wr_lo_i) rt_d.lo = wdata_i;
        if (wr_hi_i) rt_d.hi = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rt_q <= '0;
        else         rt_q <= rt_d;
    end

    assign route_lo_o = rt_q.lo;
    assign route_hi_o = rt_q.hi;
endmodule

// File: rtl/irq_route_fanout.sv
module irq_route_fanout
    import irq_hub_pkg::*;
(
    input  logic [DW-1:0]        route_lo_i,
    input  logic [DW-1:0]        route_hi_i,
    input  logic [DW-1:0]        status_i,
    input  logic [DW-1:0]        mask_i,
    output logic [NUM_ROUTE-1:0] route_irq_o
);
    logic [RF_W-1:0] fld [NUM_SIRQ];
    logic            unused_fanout;

    for (genvar i = 0; i < NUM_SIRQ; i++) begin : g_field
        if (i < SIRQ_SPLIT) begin : g_lo
            assign fld[i] = route_lo_i[route_shift(i) +: RF_W];
        end else begin : g_hi
            assign fld[i] = route_hi_i[route_shift(i) +: RF_W];
        end
    end

    assign unused_fanout = ^{route_lo_i, route_hi_i,
                             status_i[DW-NUM_SIRQ-1:0], mask_i[DW-NUM_SIRQ-1:0]};

    always_comb begin
        route_irq_o = '0;
        for (int i = 0; i < NUM_SIRQ; i++) begin
            if (status_i[DW-1-i] && mask_i[DW-1-i]) route_irq_o[fld[i]] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                reg_wr_i,
    input  logic [AW-1:0]       reg_addr_i,
    input  logic [DW-1:0]       reg_wdata_i,
    output logic [DW-1:0]       reg_rdata_o,
    input  logic [NUM_ERR-1:0]  err_evt_i,
    input  logic [DW-1:0]       err_addr_i,
    input  logic                bus_rst_evt_i,
    input  logic [NUM_BM-1:0]   bm_req_i,
    input  logic [NUM_SIRQ-1:0] sirq_req_i,
    output logic                irq_o,
    output logic [NUM_ROUTE-1:0] route_irq_o
);
    logic [DW-1:0] status_q, mask_q, eaddr_q, route_lo_q, route_hi_q;
    logic wr_stat, wr_mask, wr_lo, wr_hi;

    assign wr_stat = reg_wr_i && (reg_addr_i == OFS_STAT);
    assign wr_mask = reg_wr_i && (reg_addr_i == OFS_MASK);
    assign wr_lo   = reg_wr_i && (reg_addr_i == OFS_ROUTE_LO);
    assign wr_hi   = reg_wr_i && (reg_addr_i == OFS_ROUTE_HI);

    irq_status_regs u_stat (
        .clk_i, .rst_ni,
        .wr_stat_i(wr_stat), .wr_mask_i(wr_mask), .wdata_i(reg_wdata_i),
        .err_evt_i, .err_addr_i, .bus_rst_evt_i, .bm_req_i, .sirq_req_i,
        .status_o(status_q), .mask_o(mask_q), .eaddr_o(eaddr_q)
    );

    irq_route_regs u_route (
        .clk_i, .rst_ni,
        .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(reg_wdata_i),
        .route_lo_o(route_lo_q), .route_hi_o(route_hi_q)
    );

    irq_route_fanout u_fan (
        .route_lo_i(route_lo_q), .route_hi_i(route_hi_q),
        .status_i(status_q), .mask_i(mask_q),
        .route_irq_o(route_irq_o)
    );

    assign irq_o = |(status_q & mask_q);

    always_comb begin
        unique case (reg_addr_i)
            OFS_ROUTE_HI: reg_rdata_o = route_hi_q;
            OFS_ROUTE_LO: reg_rdata_o = route_lo_q;
            OFS_MASK:     reg_rdata_o = mask_q;
            OFS_STAT:     reg_rdata_o = status_q;
            OFS_EADDR:    reg_rdata_o = eaddr_q;
            default:      reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker
    import irq_hub_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 reg_wr_i,
    input logic [AW-1:0]        reg_addr_i,
    input logic [DW-1:0]        reg_wdata_i,
    input logic [NUM_ERR-1:0]   err_evt_i,
    input logic                 bus_rst_evt_i,
    input logic [DW-1:0]        status_q,
    input logic [DW-1:0]        mask_q,
    input logic [DW-1:0]        eaddr_q,
    input logic                 irq_o,
    input logic [NUM_ROUTE-1:0] route_irq_o
);
    assert_err_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|err_evt_i) |=> ((status_q[ERR_LSB +: NUM_ERR] & $past(err_evt_i)) == $past(err_evt_i)));

    assert_evt_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rst_evt_i |=> status_q[RST_BIT]);

    assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == OFS_STAT && reg_wdata_i[RST_BIT] && !bus_rst_evt_i)
        |=> !status_q[RST_BIT]);

    assert_eaddr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_q[ERR_LSB +: NUM_ERR] != '0) |=> $stable(eaddr_q));

    assert_route_subset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|route_irq_o) |-> irq_o);

    assert_mask_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_q == '0) |-> !irq_o);
endmodule

bind irq_hub irq_hub_checker u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .err_evt_i(err_evt_i), .bus_rst_evt_i(bus_rst_evt_i),
    .status_q(status_q), .mask_q(mask_q), .eaddr_q(eaddr_q),
    .irq_o(irq_o), .route_irq_o(route_irq_o)
);

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [5:0]  err_evt = 0;
    logic [31:0] err_addr = 0;
    logic        bus_rst_evt = 0;
    logic [1:0]  bm_req = 0;
    logic [16:0] sirq_req = 0;
    logic        irq;
    logic [3:0]  route_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_hub i_irq_hub (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .err_evt_i(err_evt),
        .err_addr_i(err_addr), .bus_rst_evt_i(bus_rst_evt), .bm_req_i(bm_req),
        .sirq_req_i(sirq_req), .irq_o(irq), .route_irq_o(route_irq)
    );

    // Behavioural reference model.
    localparam logic [31:0] IMPL = 32'hFFFF84FF;
    logic [31:0] m_stat, m_mask, m_eaddr, m_rlo, m_rhi, m_next;

    function automatic int m_route(input int i);
        if (i < 14) return int'((m_rlo >> (26 - 2*i)) & 32'h3);
        return int'((m_rhi >> (22 - 2*(i-14))) & 32'h3);
    endfunction

    function automatic logic [3:0] m_routed();
        logic [3:0] r = 0;
        for (int i = 0; i < 17; i++)
            if (m_stat[31-i] && m_mask[31-i]) r[m_route(i)] = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 0; m_mask = 0; m_eaddr = 0; m_rlo = 0; m_rhi = 0;
        end else begin
            m_next = m_stat;
            if (reg_wr && reg_addr == 8'h38) m_next = m_next & ~reg_wdata;
            for (int k = 0; k < 6; k++) if (err_evt[k]) m_next[2+k] = 1'b1;
            if (bus_rst_evt) m_next[10] = 1'b1;
            for (int k = 0; k < 2; k++) if (bm_req[k]) m_next[k] = 1'b1;
            for (int i = 0; i < 17; i++) if (sirq_req[i]) m_next[31-i] = 1'b1;
            if (err_evt != 0 && m_stat[7:2] == 0) m_eaddr = err_addr;
            if (reg_wr && reg_addr == 8'h34) m_mask = reg_wdata & IMPL;
            if (reg_wr && reg_addr == 8'h0C) m_rlo = reg_wdata;
            if (reg_wr && reg_addr == 8'h08) m_rhi = reg_wdata;
            m_stat = m_next & IMPL;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of the outputs against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq === (|(m_stat & m_mask)), "R5 irq_o vs model", 32'(irq), 32'(|(m_stat & m_mask)));
            chk(route_irq === m_routed(), "R7 route_irq_o vs model", 32'(route_irq), 32'(m_routed()));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); reg_addr = a; #1;
        chk(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic pulse_err(input int k, input logic [31:0] a);
        @(negedge clk); err_evt[k] = 1; err_addr = a;
        @(negedge clk); err_evt = 0;
    endtask

    task automatic pulse_sirq(input int i);
        @(negedge clk); sirq_req[i] = 1;
        @(negedge clk); sirq_req = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lo, hi;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        rd(8'h38, 0, "R1 status after reset");
        rd(8'h34, 0, "R1 mask after reset");
        rd(8'h40, 0, "R1 eaddr after reset");
        rd(8'h0C, 0, "R1 route lo after reset");
        rd(8'h08, 0, "R1 route hi after reset");
        chk(irq === 0 && route_irq === 0, "R1 outputs after reset", {27'd0, route_irq, irq}, 0);

        // R4 mask layout
        wr(8'h34, 32'hFFFFFFFF);
        rd(8'h34, 32'hFFFF84FF, "R4 mask implemented bits");

        // R2 source mapping, R8 first capture
        pulse_err(0, 32'hA000_0010);
        rd(8'h38, 32'h0000_0004, "R2 err0 -> bit2");
        rd(8'h40, 32'hA000_0010, "R8 capture first error address");
        pulse_err(3, 32'h0000_BBBB);
        rd(8'h38, 32'h0000_0024, "R2 err3 -> bit5");
        rd(8'h40, 32'hA000_0010, "R8 hold while error pending");
        @(negedge clk); bus_rst_evt = 1; @(negedge clk); bus_rst_evt = 0;
        @(negedge clk); bm_req = 2'b11; @(negedge clk); bm_req = 0;
        pulse_sirq(0);
        pulse_sirq(16);
        rd(8'h38, 32'h8000_8427, "R2 full status mapping");
        chk(irq === 1'b1, "R5 irq with mask set", 32'(irq), 1);
        chk(route_irq === 4'b0001, "R1 default route to output 0", 32'(route_irq), 1);

        // R5 masking
        wr(8'h34, 0);
        @(negedge clk);
        chk(irq === 1'b0 && route_irq === 0, "R5 all masked", {27'd0, route_irq, irq}, 0);
        wr(8'h34, 32'hFFFFFFFF);

        // R3 / R10 clearing
        wr(8'h38, 32'h0000_0004);
        rd(8'h38, 32'h8000_8423, "R3 w1c clears only bit2");
        wr(8'h38, 32'h0000_0000);
        rd(8'h38, 32'h8000_8423, "R10 zero write leaves status");
        @(negedge clk); reg_wr = 1; reg_addr = 8'h38; reg_wdata = 32'h400; bus_rst_evt = 1;
        @(negedge clk); reg_wr = 0; bus_rst_evt = 0;
        rd(8'h38, 32'h8000_8423, "R3 event wins over clear");
        wr(8'h38, 32'hFFFFFFFF);
        rd(8'h38, 0, "R3 clear all");

        // R8 recapture, R10 eaddr write ignored
        pulse_err(5, 32'h0000_1234);
        rd(8'h40, 32'h0000_1234, "R8 recapture after clear");
        rd(8'h38, 32'h0000_0080, "R2 err5 -> bit7");
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, 32'h0000_1234, "R10 eaddr write ignored");
        wr(8'h38, 32'hFFFFFFFF);
        rd(8'h10, 0, "R10 unmapped address reads 0");

        // R9 route readback
        wr(8'h0C, 32'hDEADBEEF);
        rd(8'h0C, 32'hDEADBEEF, "R9 route lo readback");
        wr(8'h08, 32'h12345678);
        rd(8'h08, 32'h12345678, "R9 route hi readback");

        // R6 / R7 field positions: request i -> output i mod 4
        lo = 0; hi = 0;
        for (int i = 0; i < 17; i++) begin
            if (i < 14) lo = lo | (32'(i % 4) << (26 - 2*i));
            else        hi = hi | (32'(i % 4) << (22 - 2*(i-14)));
        end
        wr(8'h0C, lo);
        wr(8'h08, hi);
        for (int i = 0; i < 17; i++) begin
            pulse_sirq(i);
            chk(route_irq === (4'b1 << (i % 4)), $sformatf("R6 R7 request %0d routing", i),
                32'(route_irq), 32'(4'b1 << (i % 4)));
            wr(8'h38, 32'hFFFFFFFF);
        end

        // R7 masked serial request does not route
        wr(8'h34, 32'h7FFFFFFF);
        pulse_sirq(0);
        chk(route_irq === 0 && irq === 0, "R7 masked request not routed", {27'd0, route_irq, irq}, 0);
        rd(8'h38, 32'h8000_0000, "R2 masked request still latched");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule